// File: doc/BRIEF.md
# Parallel Token Controller

This block is a Moore-style control unit whose state is a token vector rather than a single encoded state. Every place of a small fixed control net is one flip-flop, and a marked place reads as 1. Each transition is an AND of its input places and its firing condition. The next-state bit of a place is the OR of the transitions that feed it, plus a self-hold term that keeps the token while no outgoing transition fires. Because several places can be marked at once, two branches of the control sequence advance in the same clock cycles, and no hierarchy of cooperating controllers is needed.

The example net has a start place, a condition-gated entry into a setup place, and an unconditional fork into two branches. Each branch has one condition-gated step. A join waits for both branches, and a decision place either repeats the fork or goes to a finish place. The finish place returns to start on the next edge. The control outputs depend only on which places are marked. Each output is the OR of the place bits that assert it.

Top module: `pnet_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the start place becomes the only marked place. `ctl` then reads 0 and `done` reads 0.
- R2: With only the start place marked, the token moves to the setup place at an edge where `cond[0]` is 1, and the token stays put when `cond[0]` is 0. The setup place shows as `ctl` = 8'h01.
- R3: The setup place forks on the next edge whatever `cond` holds. It marks branch-A run (`ctl[1]`) and branch-B run (`ctl[3]`) together, giving `ctl` = 8'h0A, and the setup token is cleared.
- R4: The branches advance independently. Branch-A run moves to branch-A wait (`ctl[2]`) on `cond[1]`, and branch-B run moves to branch-B wait (`ctl[4]`) on `cond[2]`. The two steps may come in either order or on the same edge. `ctl[7]` is 1 while either wait place is marked.
- R5: The join fires only when both wait places are marked. It then marks the decision place (`ctl` = 8'h20) on the next edge without needing any condition. A branch that arrives first keeps its wait token unchanged.
- R6: From the decision place exactly one successor is marked. When `cond[3]` is 1 it is the retry place (`ctl` = 8'h41). When `cond[3]` is 0 it is the finish place (`ctl` = 0, `done` = 1).
- R7: The retry place returns its token to the setup place on the next edge (`ctl` = 8'h01). The finish place returns its token to the start place on the next edge (`ctl` = 0, `done` = 0). Neither return depends on `cond`.
- R8: The outputs are a function of the marking alone. The start place asserts no `ctl` bit. A condition bit that feeds no transition enabled in the present marking changes neither `ctl` nor `done`.
- R9: `done` is 1 exactly while the finish place is marked.
- R10: Each firing clears its input places on the same edge that marks its output places. No place is ever marked again while it still holds a token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all places update on the rising edge |
| rst | input | 1 | Synchronous reset; marks only the start place |
| cond | input | NCOND (4) | Condition inputs: bit 0 go, bit 1 branch-A step, bit 2 branch-B step, bit 3 repeat |
| ctl | output | 8 | Moore control vector decoded from the marking |
| done | output | 1 | High while the finish place is marked |

## Verification
The assertions assume that `rst` is pulsed once at start-up for a single cycle. They also assume that the net is entered only from its reset marking, so every reachable marking holds at most one token per place. The bench drives reset for exactly one edge and then moves the net only through `cond`. The condition inputs need no stability and may take any value at any edge. The bench uses this freedom: it holds conditions high at places that should ignore them and raises both branch steps on the same edge.

// File: rtl/pnet_pkg.sv
package pnet_pkg;
  localparam int NPLACE = 9;
  localparam int NCTL   = 8;

  localparam int P_START = 0;
  localparam int P_SETUP = 1;
  localparam int P_ARUN  = 2;
  localparam int P_AWAIT = 3;
  localparam int P_BRUN  = 4;
  localparam int P_BWAIT = 5;
  localparam int P_DECIDE = 6;
  localparam int P_RETRY = 7;
  localparam int P_FINISH = 8;

  localparam int C_GO    = 0;
  localparam int C_ASTEP = 1;
  localparam int C_BSTEP = 2;
  localparam int C_AGAIN = 3;
  localparam int NCOND_MIN = 4;

  localparam logic [NPLACE-1:0] INIT_MARK = NPLACE'(1) << P_START;

  // one mask per control bit: the places that assert it
  localparam logic [NPLACE-1:0] CTL_MAP [NCTL] = '{
    9'b010000010,
    9'b000000100,
    9'b000001000,
    9'b000010000,
    9'b000100000,
    9'b001000000,
    9'b010000000,
    9'b000101000
  };
endpackage

// File: rtl/pnet_place.sv
module pnet_place #(
  parameter bit INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic fill,
  input  logic drain,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= INIT;
    else     q <= (q & ~drain) | fill;
  end

  // R10: a held token is never topped up by another firing
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    !(q && fill && !drain));
endmodule

// File: rtl/pnet_fire.sv
module pnet_fire
  import pnet_pkg::*;
#(
  parameter int NCOND = 4
) (
  input  logic [NPLACE-1:0] mark,
  input  logic [NCOND-1:0]  cond,
  output logic [NPLACE-1:0] fill,
  output logic [NPLACE-1:0] drain
);
  logic t_go, t_fork, t_a, t_b, t_join, t_loop, t_exit, t_retry, t_home;

  always_comb begin
    t_go    = mark[P_START]  & cond[C_GO];
    t_fork  = mark[P_SETUP];
    t_a     = mark[P_ARUN]   & cond[C_ASTEP];
    t_b     = mark[P_BRUN]   & cond[C_BSTEP];
    t_join  = mark[P_AWAIT]  & mark[P_BWAIT];
    t_loop  = mark[P_DECIDE] & cond[C_AGAIN];
    t_exit  = mark[P_DECIDE] & ~cond[C_AGAIN];
    t_retry = mark[P_RETRY];
    t_home  = mark[P_FINISH];

    fill = '0;
    fill[P_START]  = t_home;
    fill[P_SETUP]  = t_go | t_retry;
    fill[P_ARUN]   = t_fork;
    fill[P_AWAIT]  = t_a;
    fill[P_BRUN]   = t_fork;
    fill[P_BWAIT]  = t_b;
    fill[P_DECIDE] = t_join;
    fill[P_RETRY]  = t_loop;
    fill[P_FINISH] = t_exit;

    drain = '0;
    drain[P_START]  = t_go;
    drain[P_SETUP]  = t_fork;
    drain[P_ARUN]   = t_a;
    drain[P_AWAIT]  = t_join;
    drain[P_BRUN]   = t_b;
    drain[P_BWAIT]  = t_join;
    drain[P_DECIDE] = t_loop | t_exit;
    drain[P_RETRY]  = t_retry;
    drain[P_FINISH] = t_home;
  end
endmodule

// File: rtl/pnet_decode.sv
module pnet_decode
  import pnet_pkg::*;
(
  input  logic [NPLACE-1:0] mark,
  output logic [NCTL-1:0]   ctl,
  output logic              done
);
  for (genvar i = 0; i < NCTL; i++) begin : g_ctl
    assign ctl[i] = |(mark & CTL_MAP[i]);
  end
  assign done = mark[P_FINISH];
endmodule

// File: rtl/pnet_ctrl.sv
module pnet_ctrl
  import pnet_pkg::*;
#(
  parameter int NCOND = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCOND-1:0] cond,
  output logic [NCTL-1:0]  ctl,
  output logic             done
);
  logic [NPLACE-1:0] mark, fill, drain;

  initial begin
    if (NCOND < NCOND_MIN) $error("NCOND too small for the net");
  end

  pnet_fire #(.NCOND(NCOND)) u_fire (
    .mark(mark), .cond(cond), .fill(fill), .drain(drain)
  );

  for (genvar p = 0; p < NPLACE; p++) begin : g_place
    pnet_place #(.INIT(INIT_MARK[p])) u_place (
      .clk(clk), .rst(rst), .fill(fill[p]), .drain(drain[p]), .q(mark[p])
    );
  end

  pnet_decode u_dec (.mark(mark), .ctl(ctl), .done(done));

  // R1: reset leaves only the start token
  p_reset_mark_r1: assert property (@(posedge clk)
    rst |=> (mark == INIT_MARK));
  // R3: the setup token always forks into both branches
  p_fork_r3: assert property (@(posedge clk) disable iff (rst)
    mark[P_SETUP] |=> (mark[P_ARUN] && mark[P_BRUN] && !mark[P_SETUP]));
  // R5: the decision place is reached only through a full join
  p_join_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mark[P_DECIDE]) |-> $past(mark[P_AWAIT] && mark[P_BWAIT]));
  // R5: a wait token that is alone stays where it is
  p_wait_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mark[P_AWAIT] && !mark[P_BWAIT]) |=> mark[P_AWAIT]);
  // R6: the decision place hands over to exactly one successor
  p_choice_r6: assert property (@(posedge clk) disable iff (rst)
    mark[P_DECIDE] |=> ($onehot0({mark[P_RETRY], mark[P_FINISH]}) &&
                         (mark[P_RETRY] || mark[P_FINISH])));
endmodule

// File: tb/sim_pnet_ctrl.sv
`timescale 1ns/1ps
module sim_pnet_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cond = '0;
  logic [7:0] ctl;
  logic       done;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pnet_ctrl #(.NCOND(4)) u0 (.clk(clk), .rst(rst), .cond(cond), .ctl(ctl), .done(done));

  task automatic check(input string tag, input logic [7:0] ec, input logic ed);
    checks++;
    if (ctl !== ec || done !== ed) begin
      fails++;
      $display("FAIL %s: ctl=%h done=%b expected ctl=%h done=%b", tag, ctl, done, ec, ed);
    end
  endtask

  task automatic step(input logic [3:0] c, input string tag,
                      input logic [7:0] ec, input logic ed);
    @(negedge clk);
    cond = c;
    @(posedge clk);
    #2;
    check(tag, ec, ed);
  endtask

  task automatic t_reset;
    @(posedge clk);
    #2;
    check("R1 reset marking", 8'h00, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_enter;
    step(4'b0000, "R2 start holds without go", 8'h00, 1'b0);
    step(4'b1110, "R8 unused conditions ignored at start", 8'h00, 1'b0);
    step(4'b0001, "R2 go enters setup", 8'h01, 1'b0);
    step(4'b1111, "R3 fork ignores conditions", 8'h0A, 1'b0);
  endtask

  task automatic t_a_first;
    t_enter();
    step(4'b0010, "R4 branch A steps alone", 8'h8C, 1'b0);
    step(4'b1000, "R5 early A token held", 8'h8C, 1'b0);
    step(4'b0100, "R4 branch B catches up", 8'h94, 1'b0);
    step(4'b0000, "R5 join fires", 8'h20, 1'b0);
    step(4'b1000, "R6 repeat chosen", 8'h41, 1'b0);
    step(4'b0000, "R7 retry back to setup", 8'h01, 1'b0);
    step(4'b0000, "R3 fork again", 8'h0A, 1'b0);
    step(4'b0110, "R4 both branches same edge", 8'h94, 1'b0);
    step(4'b0110, "R10 join clears both waits", 8'h20, 1'b0);
    step(4'b0111, "R6 finish chosen", 8'h00, 1'b1);
    step(4'b1111, "R7 finish returns to start", 8'h00, 1'b0);
  endtask

  task automatic t_b_first;
    t_enter();
    step(4'b0100, "R4 branch B steps alone", 8'h92, 1'b0);
    step(4'b1000, "R5 early B token held", 8'h92, 1'b0);
    step(4'b0010, "R4 branch A catches up", 8'h94, 1'b0);
    step(4'b1000, "R5 join fires after B first", 8'h20, 1'b0);
    step(4'b0000, "R9 done while finish marked", 8'h00, 1'b1);
    step(4'b0000, "R9 done drops at start", 8'h00, 1'b0);
  endtask

  initial begin
    t_reset();
    t_a_first();
    t_b_first();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule